// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a combinational sum-of-products array whose AND plane and OR plane are both set at run time. It has `NUM_IN` inputs, `NUM_TERMS` product terms and `NUM_OUT` outputs. Each product term picks, for every input, the true literal, the complemented literal, or no literal at all. Each output then ORs together whichever product terms are connected to it. Because the connections are free in both planes, one product term can feed as many outputs as needed. The array is therefore not limited to full minterms, as a decoder-based table would be.

The personality is held in registers and written one product term per cycle through a word-wide port. While `load_en` is high, every `cfg_we` pulse stores one term row: the literal codes of that row and its output connections. A small state machine tracks the configuration and has three states:

- `ST_BLANK`: the state after reset; nothing has been loaded.
- `ST_LOAD`: a load is open.
- `ST_READY`: the configuration is complete.

It has three transitions:

- `BLANK->LOAD` and `READY->LOAD`, both taken when `load_en` is sampled high.
- `LOAD->READY`, taken when `load_en` is sampled low.

`cfg_done` is high only in `ST_READY`. The outputs are held at zero whenever `cfg_done` is low, so logic downstream never sees a half-written personality.

Top module: `prog_pla`

## Requirements
- R1: After reset, `cfg_done` is 0 and `pla_out` is all zeros, whatever `pla_in` holds.
- R2: The literal code of input i in a term row is `cfg_and[2i+1:2i]`. Code 01 uses the true input, code 10 uses the complemented input, and code 00 leaves the input out of the product.
- R3: Literal code 11 is reserved and behaves exactly like 00, leaving the input out.
- R4: A product term whose inputs are all left out evaluates to 1.
- R5: Bit j of `cfg_or` connects the term to output j, and `pla_out[j]` is the OR of its connected terms. An output with no connected term is 0.
- R6: One term may feed several outputs. With inputs ordered x=`pla_in[2]`, y=`pla_in[1]`, z=`pla_in[0]`, the four terms xy'z', x'z, x'yz' and xy give `pla_out[2]` = minterms {1,2,3,4}, `pla_out[1]` = {2,6,7} and `pla_out[0]` = {4,6,7}.
- R7: A row write is stored only at a clock edge where both `load_en` and `cfg_we` are high. A write presented with `load_en` low, including on the cycle that closes a load, is discarded.
- R8: From the edge after `load_en` is sampled high, `cfg_done` is 0 and `pla_out` is all zeros until the load closes.
- R9: `cfg_done` rises on the edge after `load_en` is first sampled low following a load. Rows not written during a load keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Keeps a configuration load open while high |
| cfg_we | input | 1 | Strobes one term row into the personality |
| cfg_row | input | ROW_W | Index of the product term being written |
| cfg_and | input | 2*NUM_IN | Literal codes for the row, 2 bits per input |
| cfg_or | input | NUM_OUT | Output connections for the row, 1 bit per output |
| pla_in | input | NUM_IN | Logic inputs to the array |
| pla_out | output | NUM_OUT | Sum-of-products outputs, zero until configured |
| cfg_done | output | 1 | Configuration complete |

## Verification
A row write and the closing of a load can land on the same clock edge. The bench provokes this by presenting a write strobe on the very cycle `load_en` drops. The row it writes would make every output 1 for every input. The judgement is made at the outputs: after `cfg_done` rises, the bench evaluates the array on input patterns whose expected result under the old personality is zero. If any of those outputs reads 1, the discarded write leaked into the personality.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // 2-bit literal code for one input within one product term
    typedef enum logic [1:0] {
        LIT_OFF  = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_RSVD = 2'b11
    } lit_code_e;

    // configuration tracking states
    typedef enum logic [1:0] {
        ST_BLANK = 2'b00,
        ST_LOAD  = 2'b01,
        ST_READY = 2'b10
    } cfg_state_e;

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 4,
    parameter int NUM_OUT   = 3,
    parameter int ROW_W     = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_en,
    input  logic                            cfg_we,
    input  logic [ROW_W-1:0]                cfg_row,
    input  logic [2*NUM_IN-1:0]             cfg_and,
    input  logic [NUM_OUT-1:0]              cfg_or,
    output logic [NUM_TERMS*2*NUM_IN-1:0]   and_flat,
    output logic [NUM_TERMS*NUM_OUT-1:0]    or_flat,
    output logic                            done
);

    localparam int AW = 2 * NUM_IN;

    cfg_state_e st_q, st_d;
    logic [NUM_TERMS-1:0][AW-1:0]      and_q;
    logic [NUM_TERMS-1:0][NUM_OUT-1:0] or_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BLANK: if (load_en)  st_d = ST_LOAD;
            ST_LOAD:  if (!load_en) st_d = ST_READY;
            ST_READY: if (load_en)  st_d = ST_LOAD;
            default:                st_d = ST_BLANK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_BLANK;
        else        st_q <= st_d;
    end

    // outputs of the state machine
    always_comb begin
        done = (st_q == ST_READY);
    end

    // personality rows, one register group per product term
    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                and_q[t] <= '0;
                or_q[t]  <= '0;
            end else if (load_en && cfg_we && (cfg_row == ROW_W'(t))) begin
                and_q[t] <= cfg_and;
                or_q[t]  <= cfg_or;
            end
        end
        assign and_flat[t*AW +: AW]          = and_q[t];
        assign or_flat[t*NUM_OUT +: NUM_OUT] = or_q[t];
    end

    // R7
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(and_q) && $stable(or_q)));

    // R8
    load_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !done);

    // R9
    close_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && st_q == ST_LOAD) |=> done);

    // R9
    done_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(st_q == ST_LOAD));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 4
) (
    input  logic [NUM_IN-1:0]              pla_in,
    input  logic [NUM_TERMS*2*NUM_IN-1:0]  and_flat,
    output logic [NUM_TERMS-1:0]           term
);

    localparam int AW = 2 * NUM_IN;

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic [NUM_IN-1:0] lit_ok;
        for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
            lit_code_e code;
            assign code = lit_code_e'(and_flat[t*AW + 2*i +: 2]);
            always_comb begin
                unique case (code)
                    LIT_TRUE: lit_ok[i] = pla_in[i];
                    LIT_COMP: lit_ok[i] = ~pla_in[i];
                    LIT_OFF:  lit_ok[i] = 1'b1;
                    LIT_RSVD: lit_ok[i] = 1'b1;
                    default:  lit_ok[i] = 1'b1;
                endcase
            end
        end
        assign term[t] = &lit_ok;
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int NUM_TERMS = 4,
    parameter int NUM_OUT   = 3
) (
    input  logic [NUM_TERMS-1:0]          term,
    input  logic [NUM_TERMS*NUM_OUT-1:0]  or_flat,
    output logic [NUM_OUT-1:0]            sum
);

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_sum
        logic [NUM_TERMS-1:0] col;
        for (genvar t = 0; t < NUM_TERMS; t++) begin : g_col
            assign col[t] = or_flat[t*NUM_OUT + j];
        end
        assign sum[j] = |(term & col);
    end

endmodule

// File: rtl/prog_pla.sv
module prog_pla #(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 4,
    parameter int NUM_OUT   = 3,
    parameter int ROW_W     = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic                 cfg_we,
    input  logic [ROW_W-1:0]     cfg_row,
    input  logic [2*NUM_IN-1:0]  cfg_and,
    input  logic [NUM_OUT-1:0]   cfg_or,
    input  logic [NUM_IN-1:0]    pla_in,
    output logic [NUM_OUT-1:0]   pla_out,
    output logic                 cfg_done
);

    logic [NUM_TERMS*2*NUM_IN-1:0] and_flat;
    logic [NUM_TERMS*NUM_OUT-1:0]  or_flat;
    logic [NUM_TERMS-1:0]          term;
    logic [NUM_OUT-1:0]            sum;

    pla_cfg_store #(
        .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT), .ROW_W(ROW_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_we(cfg_we),
        .cfg_row(cfg_row), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .and_flat(and_flat), .or_flat(or_flat), .done(cfg_done)
    );

    pla_and_plane #(.NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS)) u_and (
        .pla_in(pla_in), .and_flat(and_flat), .term(term)
    );

    pla_or_plane #(.NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT)) u_or (
        .term(term), .or_flat(or_flat), .sum(sum)
    );

    assign pla_out = cfg_done ? sum : '0;

    // R8
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (pla_out == '0));

endmodule

// File: tb/prog_pla_tb.sv
module prog_pla_tb;

    localparam int K = 3, M = 4, N = 3, RW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [RW-1:0] cfg_row = '0;
    logic [2*K-1:0] cfg_and = '0;
    logic [N-1:0]  cfg_or = '0;
    logic [K-1:0]  pla_in = '0;
    logic [N-1:0]  pla_out;
    logic          cfg_done;

    int checks = 0;
    int errors = 0;

    // expected outputs of the three-function example, indexed by {x,y,z}
    localparam logic [N-1:0] EXP [8] = '{3'b000, 3'b100, 3'b110, 3'b100,
                                        3'b101, 3'b000, 3'b011, 3'b011};

    always #2.5 clk = ~clk;

    prog_pla u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_we(cfg_we),
        .cfg_row(cfg_row), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .pla_in(pla_in), .pla_out(pla_out), .cfg_done(cfg_done)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic put_row(input logic [RW-1:0] r, input logic [2*K-1:0] a, input logic [N-1:0] o);
        @(negedge clk);
        cfg_we = 1'b1; cfg_row = r; cfg_and = a; cfg_or = o;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string req, input logic [K-1:0] v, input logic [N-1:0] exp);
        pla_in = v;
        #1;
        chk(req, pla_out, exp);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pla_in = 3'b111; #1;
        chk("R1 done", {2'b00, cfg_done}, 3'b000);
        chk("R1 out", pla_out, 3'b000);

        // load the three-function example
        load_en = 1'b1;
        put_row(2'd0, 6'b01_10_10, 3'b101); // x y' z'
        put_row(2'd1, 6'b10_00_01, 3'b100); // x' z
        put_row(2'd2, 6'b10_01_10, 3'b110); // x' y z'
        put_row(2'd3, 6'b01_01_00, 3'b011); // x y
        pla_in = 3'b100; #1;
        chk("R8 out during load", pla_out, 3'b000);
        chk("R8 done during load", {2'b00, cfg_done}, 3'b000);

        // close the load while presenting a write that must be dropped (R7)
        @(negedge clk);
        load_en = 1'b0;
        cfg_we = 1'b1; cfg_row = 2'd3; cfg_and = 6'b00_00_00; cfg_or = 3'b111;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R9 done after close", {2'b00, cfg_done}, 3'b001);

        // R6 R2 R5: walk the truth table
        for (int v = 0; v < 8; v++) begin
            probe("R6 example", 3'(v), EXP[v]);
        end
        probe("R7 dropped write", 3'd0, 3'b000);
        probe("R7 dropped write", 3'd5, 3'b000);

        // reload only row 3: all reserved codes, feeds output 0 only
        @(negedge clk);
        load_en = 1'b1;
        @(negedge clk);
        #1;
        chk("R8 done cleared by reload", {2'b00, cfg_done}, 3'b000);
        put_row(2'd3, 6'b11_11_11, 3'b001);
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        // R3 R4: row 3 is constant 1 on output 0; R9: other rows retained
        probe("R4 always-true term", 3'd5, 3'b001);
        probe("R3 reserved code", 3'd0, 3'b001);
        probe("R9 retained rows", 3'd1, 3'b101);
        probe("R9 retained rows", 3'd2, 3'b111);

        // R5: disconnect row 2 from output 1, leaving output 1 with no terms
        @(negedge clk);
        load_en = 1'b1;
        put_row(2'd2, 6'b10_01_10, 3'b100);
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        probe("R5 empty output", 3'd2, 3'b101);
        probe("R5 empty output", 3'd7, 3'b001);

        // R7: a write with load_en low while ready is ignored
        put_row(2'd1, 6'b00_00_00, 3'b010);
        probe("R7 write while idle", 3'd5, 3'b001);
        chk("R7 done kept", {2'b00, cfg_done}, 3'b001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule